// File: doc/BRIEF.md
# Thermal-Aware Frame Governor

This block decides, once per frame, how fast a processing core should run and whether it must stop. It measures the cycles spent on each frame and compares them with a worst-case execution budget and with the frame period. It also compares the most recent temperature sample with three programmable limits. When a frame finishes early, the core is stepped one operating level slower to reclaim slack. When a frame overruns its budget and the core is not too hot, the core is stepped one level faster. When a frame overruns the whole period, the following frame is dropped.

A temperature above the critical limit overrides all timing decisions. It forces the core into an idle state at the stopped level and abandons any frame in progress. The idle state is held until the temperature falls below the low limit, so the core cannot bounce in and out of idle. Typical limits are 70 °C for the low limit and 90 °C for the high and critical limits, which keeps the die under a 95 °C budget.

Top module: `thermal_frame_governor`

## Requirements
- R1: After synchronous reset, `op_level` is 0, `idle_req` is 0, `frame_skip` is 0, no frame is in progress, and `next_grant` is 1.
- R2: `op_level` encodes 0=500 MHz, 1=375 MHz, 2=187.5 MHz, 3=68.75 MHz and 4=stopped. Timing-driven steps saturate at 0 (fastest) and 3. Level 4 appears exactly while `idle_req` is 1. Outside idle, a level changes by at most one step between consecutive cycles.
- R3: Elapsed time is the number of clock edges after the edge that accepts `frame_start`. If `frame_done` arrives with elapsed time below `wcet_cycles` and no adjustment has yet been made in that frame, the level increases by one.
- R4: When the elapsed time of a running frame first exceeds `wcet_cycles`, the frame's single adjustment is used up. The level decreases by one only if the latched temperature is below `thr_high`. No frame makes more than one level adjustment.
- R5: When the elapsed time of a running frame exceeds `period_cycles`, `frame_skip` is set. The next accepted `frame_start` does not start a frame, and it clears `frame_skip`.
- R6: A latched temperature strictly above `thr_crit` sets `idle_req` and level 4 two edges after the sample strobe, and abandons any running frame.
- R7: While idle, the block leaves idle only when the latched temperature is strictly below `thr_low`. On leaving idle it resumes at level 3.
- R8: `next_grant` is 1 exactly when the block is not idle and no frame is running. A `frame_start` while `next_grant` is 0 is ignored.
- R9: `temp_in` is captured only on edges where `temp_valid` is 1, and all comparisons use the captured value.
- R10: When conditions coincide in one cycle, the critical override wins over the frame skip, and the frame skip wins over a level adjustment. A skip also uses up that frame's adjustment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Pulse requesting a new frame |
| frame_done | input | 1 | Pulse marking the end of the running frame |
| temp_valid | input | 1 | Strobe qualifying `temp_in` |
| temp_in | input | TEMP_W | Temperature sample, unsigned whole °C |
| wcet_cycles | input | CNT_W | Worst-case execution budget in cycles |
| period_cycles | input | CNT_W | Frame period (deadline) in cycles |
| thr_low | input | TEMP_W | Low temperature limit (idle exit) |
| thr_high | input | TEMP_W | High temperature limit (speed-up gate) |
| thr_crit | input | TEMP_W | Critical temperature limit (idle entry) |
| op_level | output | LVL_W | Operating level index, 0 fastest, 4 stopped |
| idle_req | output | 1 | Forced idle request |
| frame_skip | output | 1 | Next frame will be dropped |
| next_grant | output | 1 | A new frame may start |

## Verification
The budget overrun and the deadline miss can happen on the same edge. The bench provokes this by programming equal budget and period values and running a frame past both while the core sits at level 3. It then checks that `frame_skip` is set and that the level stays at 3 instead of stepping to 2. A second overlap is a critical sample arriving during a running frame. It is judged by checking that the block goes idle at level 4, that the frame is abandoned, and that after cooling the block resumes at level 3 with `next_grant` high.

// File: rtl/tfg_pkg.sv
// Shared constants and types for the thermal frame governor.
// Assumes five operating levels, with index 0 the fastest.
package tfg_pkg;
    localparam int NUM_LEVELS = 5;
    localparam int LVL_W      = $clog2(NUM_LEVELS);
    localparam logic [LVL_W-1:0] LVL_FASTEST  = LVL_W'(0);
    localparam logic [LVL_W-1:0] LVL_SLOW_RUN = LVL_W'(NUM_LEVELS - 2);
    localparam logic [LVL_W-1:0] LVL_STOPPED  = LVL_W'(NUM_LEVELS - 1);

    typedef logic [LVL_W-1:0] level_t;

    // Results of comparing the captured temperature with the three limits.
    typedef struct packed {
        logic below_low;
        logic below_high;
        logic above_crit;
    } therm_flags_t;
endpackage

// File: rtl/tfg_temp_eval.sv
// Captures the temperature sample on its strobe and compares the captured
// value with the low, high and critical limits.
// Assumes the limits are quasi-static; the flags follow the held sample.
module tfg_temp_eval
    import tfg_pkg::*;
#(
    parameter int TEMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              temp_valid,
    input  logic [TEMP_W-1:0] temp_in,
    input  logic [TEMP_W-1:0] thr_low,
    input  logic [TEMP_W-1:0] thr_high,
    input  logic [TEMP_W-1:0] thr_crit,
    output therm_flags_t      flags
);
    logic [TEMP_W-1:0] temp_q;

    // Hold the last qualified sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            temp_q <= '0;
        else if (temp_valid)
            temp_q <= temp_in;
    end

    // Threshold comparisons on the held sample.
    always_comb begin
        flags.below_low  = temp_q < thr_low;
        flags.below_high = temp_q < thr_high;
        flags.above_crit = temp_q > thr_crit;
    end
endmodule

// File: rtl/tfg_frame_timer.sv
// Counts the cycles of the running frame and flags budget and deadline overruns.
// Assumes a start is only accepted while no frame runs; an abort ends the frame.
module tfg_frame_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_acc,
    input  logic             done_in,
    input  logic             abort,
    input  logic [CNT_W-1:0] wcet_cycles,
    input  logic [CNT_W-1:0] period_cycles,
    output logic             busy,
    output logic             over_wcet,
    output logic             over_period,
    output logic             done_under
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] elapsed;

    // Frame-in-progress flag and saturating elapsed-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            elapsed <= '0;
        end else if (abort) begin
            busy    <= 1'b0;
        end else if (start_acc) begin
            busy    <= 1'b1;
            elapsed <= '0;
        end else if (busy) begin
            if (done_in)
                busy <= 1'b0;
            else if (elapsed != CNT_MAX)
                elapsed <= elapsed + 1'b1;
        end
    end

    // Overrun and early-completion indications for the level controller.
    always_comb begin
        over_wcet   = busy && (elapsed > wcet_cycles);
        over_period = busy && (elapsed > period_cycles);
        done_under  = busy && done_in && (elapsed < wcet_cycles);
    end
endmodule

// File: rtl/tfg_level_ctrl.sv
// Chooses the operating level, the idle state and the skip flag, and gates
// frame starts. Critical override first, then skip, then one adjustment a frame.
// Assumes the timer flags are valid only while its busy output is high.
module tfg_level_ctrl
    import tfg_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_start,
    input  therm_flags_t flags,
    input  logic         busy,
    input  logic         over_wcet,
    input  logic         over_period,
    input  logic         done_under,
    output level_t       level,
    output logic         idle,
    output logic         skip,
    output logic         grant,
    output logic         start_acc,
    output logic         abort
);
    logic adjusted;
    logic drop;

    // Start gating: a granted start either opens a frame or is dropped.
    always_comb begin
        grant     = !idle && !busy;
        start_acc = frame_start && grant && !skip;
        drop      = frame_start && grant && skip;
        abort     = flags.above_crit;
    end

    // Prioritised level, idle and skip decisions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level    <= LVL_FASTEST;
            idle     <= 1'b0;
            skip     <= 1'b0;
            adjusted <= 1'b0;
        end else if (flags.above_crit) begin
            idle     <= 1'b1;
            level    <= LVL_STOPPED;
            adjusted <= 1'b1;
        end else if (idle) begin
            if (flags.below_low) begin
                idle  <= 1'b0;
                level <= LVL_SLOW_RUN;
            end
        end else begin
            if (drop)
                skip <= 1'b0;
            if (start_acc)
                adjusted <= 1'b0;
            if (over_period) begin
                skip     <= 1'b1;
                adjusted <= 1'b1;
            end else if (over_wcet && !adjusted) begin
                adjusted <= 1'b1;
                if (flags.below_high && level != LVL_FASTEST)
                    level <= level - 1'b1;
            end else if (done_under && !adjusted) begin
                adjusted <= 1'b1;
                if (level < LVL_SLOW_RUN)
                    level <= level + 1'b1;
            end
        end
    end
endmodule

// File: rtl/thermal_frame_governor.sv
// Top of the per-core thermal frame governor: temperature capture, frame
// timer and level controller. Assumes pulses are synchronous to clk.
module thermal_frame_governor
    import tfg_pkg::*;
#(
    parameter int TEMP_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              frame_done,
    input  logic              temp_valid,
    input  logic [TEMP_W-1:0] temp_in,
    input  logic [CNT_W-1:0]  wcet_cycles,
    input  logic [CNT_W-1:0]  period_cycles,
    input  logic [TEMP_W-1:0] thr_low,
    input  logic [TEMP_W-1:0] thr_high,
    input  logic [TEMP_W-1:0] thr_crit,
    output logic [LVL_W-1:0]  op_level,
    output logic              idle_req,
    output logic              frame_skip,
    output logic              next_grant
);
    therm_flags_t flags;
    logic busy, over_wcet, over_period, done_under, start_acc, abort;
    level_t level;

    tfg_temp_eval #(.TEMP_W(TEMP_W)) u_temp (
        .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_in(temp_in),
        .thr_low(thr_low), .thr_high(thr_high), .thr_crit(thr_crit), .flags(flags)
    );

    tfg_frame_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .done_in(frame_done),
        .abort(abort), .wcet_cycles(wcet_cycles), .period_cycles(period_cycles),
        .busy(busy), .over_wcet(over_wcet), .over_period(over_period),
        .done_under(done_under)
    );

    tfg_level_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .flags(flags),
        .busy(busy), .over_wcet(over_wcet), .over_period(over_period),
        .done_under(done_under), .level(level), .idle(idle_req),
        .skip(frame_skip), .grant(next_grant), .start_acc(start_acc),
        .abort(abort)
    );

    assign op_level = level;
endmodule

// File: rtl/tfg_checker.sv
// Port-level properties of the governor, attached to every instance by bind.
// Assumes the limits stay stable around a critical sample.
module tfg_checker #(
    parameter int TEMP_W = 8,
    parameter int LVL_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              temp_valid,
    input logic [TEMP_W-1:0] temp_in,
    input logic [TEMP_W-1:0] thr_crit,
    input logic [LVL_W-1:0]  op_level,
    input logic              idle_req,
    input logic              frame_skip,
    input logic              next_grant
);
    logic armed;

    // Marks that at least one cycle has passed since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r2_idle_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        idle_req |-> (op_level == LVL_W'(4)));

    a_r2_run_range: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_req |-> (op_level <= LVL_W'(3)));

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (!idle_req && !$past(idle_req)) |->
        ((op_level == $past(op_level)) || (op_level == $past(op_level) + 1'b1) ||
         (op_level + 1'b1 == $past(op_level))));

    a_r6_crit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_valid && (temp_in > thr_crit)) |-> ##2 idle_req);

    a_r8_no_grant_idle: assert property (@(posedge clk) disable iff (!rst_n)
        idle_req |-> !next_grant);

    a_r5_skip_clear: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $fell(frame_skip) |-> $past(frame_start));
endmodule

bind thermal_frame_governor tfg_checker #(.TEMP_W(TEMP_W), .LVL_W(tfg_pkg::LVL_W)) u_tfg_checker (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .temp_valid(temp_valid),
    .temp_in(temp_in), .thr_crit(thr_crit), .op_level(op_level),
    .idle_req(idle_req), .frame_skip(frame_skip), .next_grant(next_grant)
);

// File: tb/thermal_frame_governor_bench.sv
module thermal_frame_governor_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0, frame_done = 1'b0, temp_valid = 1'b0;
    logic [7:0]  temp_in = '0;
    logic [15:0] wcet_cycles = 16'd20, period_cycles = 16'd40;
    logic [7:0]  thr_low = 8'd70, thr_high = 8'd90, thr_crit = 8'd90;
    logic [2:0]  op_level;
    logic idle_req, frame_skip, next_grant;
    int checks = 0, errors = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    thermal_frame_governor u_thermal_frame_governor (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_done(frame_done),
        .temp_valid(temp_valid), .temp_in(temp_in), .wcet_cycles(wcet_cycles),
        .period_cycles(period_cycles), .thr_low(thr_low), .thr_high(thr_high),
        .thr_crit(thr_crit), .op_level(op_level), .idle_req(idle_req),
        .frame_skip(frame_skip), .next_grant(next_grant)
    );

    // {temperature, frame length in cycles, expected level, expected skip}
    localparam logic [31:0] VEC [11] = '{
        {8'd50, 8'd10, 8'd1, 8'd0},  // R3 early finish
        {8'd50, 8'd10, 8'd2, 8'd0},  // R3
        {8'd50, 8'd10, 8'd3, 8'd0},  // R3
        {8'd50, 8'd10, 8'd3, 8'd0},  // R2 saturate at 3
        {8'd50, 8'd30, 8'd2, 8'd0},  // R4 overrun, cool
        {8'd85, 8'd30, 8'd1, 8'd0},  // R4
        {8'd89, 8'd30, 8'd0, 8'd0},  // R4 just below high
        {8'd60, 8'd30, 8'd0, 8'd0},  // R2 saturate at 0
        {8'd60, 8'd10, 8'd1, 8'd0},  // R3
        {8'd90, 8'd30, 8'd1, 8'd0},  // R4 blocked at high, R6 not critical
        {8'd50, 8'd50, 8'd0, 8'd1}   // R4 then R5 deadline miss
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_temp(input logic [7:0] t);
        @(negedge clk); temp_in = t; temp_valid = 1'b1;
        @(negedge clk); temp_valid = 1'b0; temp_in = 8'd0;  // R9 value ignored without strobe
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic run_frame(input int n);
        pulse_start();
        chk("R8 grant low in frame", int'(next_grant), 0);
        repeat (n - 2) @(negedge clk);
        frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 level", int'(op_level), 0);
        chk("R1 idle", int'(idle_req), 0);
        chk("R1 skip", int'(frame_skip), 0);
        chk("R1 grant", int'(next_grant), 1);

        for (int i = 0; i < 11; i++) begin
            set_temp(VEC[i][31:24]);
            run_frame(int'(VEC[i][23:16]));
            chk("R3/R4 level", int'(op_level), int'(VEC[i][15:8]));
            chk("R5 skip", int'(frame_skip), int'(VEC[i][7:0]));
            chk("R2 idle", int'(idle_req), 0);
        end

        // R5: the start after a miss is dropped and clears the flag
        pulse_start();
        chk("R5 dropped start keeps grant", int'(next_grant), 1);
        chk("R5 skip cleared", int'(frame_skip), 0);
        run_frame(10);
        chk("R5 frames resume", int'(op_level), 1);

        // R6/R7: critical entry, hysteresis, exit at level 3
        set_temp(8'd95);
        chk("R6 idle", int'(idle_req), 1);
        chk("R6 level stopped", int'(op_level), 4);
        chk("R8 grant idle", int'(next_grant), 0);
        set_temp(8'd80);
        pulse_start();
        chk("R7 still idle in band", int'(idle_req), 1);
        chk("R8 start ignored", int'(next_grant), 0);
        set_temp(8'd70);
        chk("R7 not below low", int'(idle_req), 1);
        set_temp(8'd65);
        chk("R7 exit idle", int'(idle_req), 0);
        chk("R7 resume level", int'(op_level), 3);
        chk("R8 grant after exit", int'(next_grant), 1);

        // R6/R10: critical during a frame abandons it
        pulse_start();
        repeat (3) @(negedge clk);
        set_temp(8'd100);
        chk("R10 crit in frame idle", int'(idle_req), 1);
        set_temp(8'd60);
        chk("R6 frame abandoned", int'(next_grant), 1);
        chk("R7 level after abort", int'(op_level), 3);

        // R10: budget and deadline crossed on the same edge
        period_cycles = 16'd20;
        set_temp(8'd50);
        run_frame(30);
        chk("R10 skip wins", int'(frame_skip), 1);
        chk("R10 no speed-up", int'(op_level), 3);

        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule